// File: doc/BRIEF.md
# Zero-Crossing Full-Bridge PWM Swapper

This block produces the four gate drives of a grid-tied full-bridge inverter from one symmetric up-down carrier. At any time one leg runs at the carrier frequency, with its low side the dead-time-separated complement of its high side. The other leg is parked. Its high side is held off, and its low side leaves the dead-time path and follows a static level. That level is set high once by a force pulse and is then moved by a delayed-protection level: a rising edge of that level clears it and a falling edge sets it again.

A polarity flag from the controller selects which leg is active. The block samples the flag at the carrier zero point and records the result as a single mode bit. That bit moves each leg's low side between dead-time mode and parked mode, and it routes the duty compare to the active leg and the period value to the parked one. The cycle-by-cycle trip is also steered by the mode bit. It blanks both high sides and the dead-time low side, but it never touches the parked low side. A trip is latched until the first carrier zero at which the trip input is inactive.

Top module: `fbz_pwm`

## Requirements
- R1: The carrier `ctr` counts 0 up to P and back down to 0, so one carrier window is 2P clocks. P is `period_in`, and the block samples it whenever `ctr` is 0. Whenever `ctr` is non-zero it changes on every clock. After reset, `ctr` reads 0.
- R2: The active leg's high side is high for 2(P−C)−D clocks per window. C is the duty compare, limited to the range 1..P, and any value above P acts as P. D is `db_len`.
- R3: The active leg's low side is the inverse of its undelayed high side, with each of its rising edges held back by D clocks. It is high for 2C−D clocks per window.
- R4: The parked leg's high side stays low. Its low side equals the static level, with no dead time applied.
- R5: `cycle_pos` = 1 makes leg 1 (`hs1`/`ls1`) active, and `cycle_pos` = 0 makes leg 2 active. `cycle_pos` takes the value of `pos_cycle` only at a clock where `ctr` is 0, so it changes once per polarity transition and never in the middle of a window.
- R6: The static level is 0 after reset. A `stat_force` pulse sets it to 1. A rising edge of `dly_trip` clears it on the next clock, and a falling edge sets it on the next clock. An edge of `dly_trip` takes priority over `stat_force`.
- R7: While `trip_active` is 1, both high sides and the active leg's low side are low. The parked low side still follows the static level.
- R8: `trip_active` is `cbc_trip` ORed with a latch. The latch is set by `cbc_trip` and is cleared by a clock at which `ctr` is 0 and `cbc_trip` is 0. Away from the zero point, the latch holds.
- R9: The high side and the low side of one leg are never high together, including across a change of mode.
- R10: While reset is asserted, all four gate outputs, `ctr` and `trip_active` are 0. This holds when `db_len` is at least 1 and `cbc_trip` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_cycle | input | 1 | Requested polarity (1 = positive half cycle) |
| duty_cmp | input | CNT_W | Duty compare for the active leg |
| period_in | input | CNT_W | Carrier peak value P |
| db_len | input | DB_W | Dead time in clocks |
| cbc_trip | input | 1 | Cycle-by-cycle trip request |
| dly_trip | input | 1 | Delayed-protection level |
| stat_force | input | 1 | One-shot force of the static level high |
| hs1 | output | 1 | Leg 1 high-side gate |
| ls1 | output | 1 | Leg 1 low-side gate |
| hs2 | output | 1 | Leg 2 high-side gate |
| ls2 | output | 1 | Leg 2 low-side gate |
| ctr | output | CNT_W | Carrier count |
| cycle_pos | output | 1 | Applied polarity mode |
| trip_active | output | 1 | Trip blanking in force |

## Verification
The properties take for granted that `period_in` is held steady across each window and that `duty_cmp` stays between 1 and P, so that every compare event lies inside the window. The stimulus changes its settings only on clocks after a zero point, and it lets three windows pass before it measures one. Trip pulses and `dly_trip` edges are applied away from the zero point, so each effect can be traced to one cause. The dead time is at least 1 whenever reset is asserted, which gives the reset values.

// File: rtl/fbz_pkg.sv
package fbz_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
  typedef enum logic {LOW_DEADTIME = 1'b0, LOW_PARKED = 1'b1} low_mode_e;
  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/fbz_counter.sv
module fbz_counter
  import fbz_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_in,
  output logic [CNT_W-1:0] cnt,
  output dir_e             dir,
  output logic             zero,
  output logic [CNT_W-1:0] period_q
);
  logic [CNT_W-1:0] cnt_n, per_eff, per_n;
  dir_e             dir_n;

  assign zero    = (cnt == '0);
  assign per_eff = zero ? period_in : period_q;
  assign per_n   = zero ? period_in : period_q;

  always_comb begin
    cnt_n = cnt;
    dir_n = dir;
    if (per_eff == '0) begin
      cnt_n = '0;
      dir_n = DIR_UP;
    end else if (dir == DIR_UP) begin
      cnt_n = cnt + CNT_W'(1);
      dir_n = (cnt_n == per_eff) ? DIR_DOWN : DIR_UP;
    end else begin
      cnt_n = cnt - CNT_W'(1);
      dir_n = (cnt == CNT_W'(1)) ? DIR_UP : DIR_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir      <= DIR_UP;
      period_q <= '0;
    end else begin
      cnt      <= cnt_n;
      dir      <= dir_n;
      period_q <= per_n;
    end
  end
endmodule

// File: rtl/fbz_deadband.sv
module fbz_deadband #(
  parameter int unsigned DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic [DB_W-1:0] db_len,
  output logic            dout
);
  logic [DB_W-1:0] run_q, run_n;

  always_comb begin
    if (!din)               run_n = '0;
    else if (run_q == '1)   run_n = run_q;
    else                    run_n = run_q + DB_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_n;
  end

  assign dout = din && (run_q >= db_len);
endmodule

// File: rtl/fbz_leg.sv
module fbz_leg
  import fbz_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DB_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  dir_e             dir,
  input  logic             zero,
  input  logic [CNT_W-1:0] period_q,
  input  logic [CNT_W-1:0] cmp,
  input  logic [DB_W-1:0]  db_len,
  input  low_mode_e        low_mode,
  input  logic             stat_lvl,
  input  logic             trip_f,
  output logic             hs,
  output logic             ls
);
  logic h_q, h_n, hs_db, ls_db;

  always_comb begin
    h_n = h_q;
    if (zero)                             h_n = 1'b0;
    else if (cnt == period_q)             h_n = (cmp < period_q);
    else if (dir == DIR_UP && cnt == cmp) h_n = 1'b1;
    else if (cnt == cmp)                  h_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_q <= 1'b0;
    else        h_q <= h_n;
  end

  fbz_deadband #(.DB_W(DB_W)) u_db_hi (
    .clk(clk), .rst_n(rst_n), .din(h_q), .db_len(db_len), .dout(hs_db)
  );
  fbz_deadband #(.DB_W(DB_W)) u_db_lo (
    .clk(clk), .rst_n(rst_n), .din(~h_q), .db_len(db_len), .dout(ls_db)
  );

  assign hs = hs_db && !trip_f;
  assign ls = (low_mode == LOW_PARKED) ? stat_lvl : (ls_db && !trip_f);
endmodule

// File: rtl/fbz_pwm.sv
module fbz_pwm
  import fbz_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DB_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_cycle,
  input  logic [CNT_W-1:0] duty_cmp,
  input  logic [CNT_W-1:0] period_in,
  input  logic [DB_W-1:0]  db_len,
  input  logic             cbc_trip,
  input  logic             dly_trip,
  input  logic             stat_force,
  output logic             hs1,
  output logic             ls1,
  output logic             hs2,
  output logic             ls2,
  output logic [CNT_W-1:0] ctr,
  output logic             cycle_pos,
  output logic             trip_active
);
  dir_e             dir;
  logic             zero;
  logic [CNT_W-1:0] period_q, duty_cl;
  logic             pos_q, pos_n, stat_q, stat_n, dly_q, trip_q, trip_n;
  logic             dly_rise, dly_fall;
  logic [CNT_W-1:0] cmp_q [NUM_LEGS];
  logic [CNT_W-1:0] cmp_n [NUM_LEGS];
  logic             hs_w  [NUM_LEGS];
  logic             ls_w  [NUM_LEGS];

  fbz_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .period_in(period_in),
    .cnt(ctr), .dir(dir), .zero(zero), .period_q(period_q)
  );

  assign duty_cl  = (duty_cmp > period_in) ? period_in : duty_cmp;
  assign pos_n    = (zero && (pos_cycle != pos_q)) ? pos_cycle : pos_q;
  assign dly_rise = dly_trip && !dly_q;
  assign dly_fall = !dly_trip && dly_q;

  always_comb begin
    stat_n = stat_q;
    if (dly_rise)        stat_n = 1'b0;
    else if (dly_fall)   stat_n = 1'b1;
    else if (stat_force) stat_n = 1'b1;
  end

  always_comb begin
    trip_n = trip_q;
    if (cbc_trip)  trip_n = 1'b1;
    else if (zero) trip_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= 1'b1;
      stat_q <= 1'b0;
      dly_q  <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      pos_q  <= pos_n;
      stat_q <= stat_n;
      dly_q  <= dly_trip;
      trip_q <= trip_n;
    end
  end

  assign trip_active = cbc_trip || trip_q;
  assign cycle_pos   = pos_q;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    localparam logic LEG_POS = (g == 0);
    low_mode_e mode;

    assign cmp_n[g] = !zero ? cmp_q[g] :
                      (pos_cycle == LEG_POS) ? duty_cl : period_in;
    assign mode     = (pos_q == LEG_POS) ? LOW_DEADTIME : LOW_PARKED;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cmp_q[g] <= '1;
      else if (zero) cmp_q[g] <= cmp_n[g];
    end

    fbz_leg #(.CNT_W(CNT_W), .DB_W(DB_W)) u_leg (
      .clk(clk), .rst_n(rst_n), .cnt(ctr), .dir(dir), .zero(zero),
      .period_q(period_q), .cmp(cmp_q[g]), .db_len(db_len),
      .low_mode(mode), .stat_lvl(stat_q), .trip_f(trip_active),
      .hs(hs_w[g]), .ls(ls_w[g])
    );
  end

  assign hs1 = hs_w[0];
  assign ls1 = ls_w[0];
  assign hs2 = hs_w[1];
  assign ls2 = ls_w[1];
endmodule

// File: rtl/fbz_pwm_chk.sv
module fbz_pwm_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cbc_trip,
  input logic             dly_trip,
  input logic             hs1,
  input logic             ls1,
  input logic             hs2,
  input logic             ls2,
  input logic [CNT_W-1:0] ctr,
  input logic             cycle_pos,
  input logic             trip_active
);
  // R9
  no_shoot1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs1 && ls1));
  // R9
  no_shoot2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs2 && ls2));
  // R7
  trip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cbc_trip |-> (!hs1 && !hs2));
  // R4
  idle_leg2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_pos |-> !hs2);
  // R4
  idle_leg1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_pos |-> !hs1);
  // R5
  mode_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cycle_pos) |-> ($past(ctr) == '0));
  // R6
  static_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_pos && ctr != '0 && $rose(dly_trip)) |=> !ls2);
  // R8
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_active && !cbc_trip && ctr != '0) |=> trip_active);
  // R1
  ctr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr != '0) |=> (ctr != $past(ctr)));
endmodule

bind fbz_pwm fbz_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cbc_trip(cbc_trip), .dly_trip(dly_trip),
  .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2), .ctr(ctr),
  .cycle_pos(cycle_pos), .trip_active(trip_active)
);

// File: tb/fbz_pwm_tb.sv
module fbz_pwm_tb;
  localparam int CNT_W = 16;
  localparam int DB_W  = 8;

  typedef struct {
    int    len, h1, l1, h2, l2;
    string tag;
  } win_t;

  logic             clk, rst_n;
  logic             pos_cycle, cbc_trip, dly_trip, stat_force;
  logic [CNT_W-1:0] duty_cmp, period_in, ctr;
  logic [DB_W-1:0]  db_len;
  logic             hs1, ls1, hs2, ls2, cycle_pos, trip_active;

  int   n_chk = 0, n_fail = 0, n_shoot = 0;
  win_t exp_q[$];
  bit   armed = 0;
  int   c_len, c_h1, c_l1, c_h2, c_l2;

  fbz_pwm #(.CNT_W(CNT_W), .DB_W(DB_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pos_cycle(pos_cycle), .duty_cmp(duty_cmp),
    .period_in(period_in), .db_len(db_len), .cbc_trip(cbc_trip),
    .dly_trip(dly_trip), .stat_force(stat_force), .hs1(hs1), .ls1(ls1),
    .hs2(hs2), .ls2(ls2), .ctr(ctr), .cycle_pos(cycle_pos),
    .trip_active(trip_active)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_zeros(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (ctr != '0) @(negedge clk);
    end
  endtask

  task automatic apply(bit pol, int duty, int per, int db, bit trip, bit dly);
    @(posedge clk); #1;
    pos_cycle = pol; duty_cmp = CNT_W'(duty); period_in = CNT_W'(per);
    db_len = DB_W'(db); cbc_trip = trip; dly_trip = dly;
  endtask

  task automatic expect_win(int len, int h1, int l1, int h2, int l2, string tag);
    win_t w;
    wait_zeros(3);
    w.len = len; w.h1 = h1; w.l1 = l1; w.h2 = h2; w.l2 = l2; w.tag = tag;
    exp_q.push_back(w);
    @(negedge clk);
    while (exp_q.size() != 0 || armed) @(negedge clk);
  endtask

  // Monitor: measures one carrier window per queued item
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if ((hs1 && ls1) || (hs2 && ls2)) n_shoot++;
        if (ctr == '0) begin
          if (armed) begin
            win_t w;
            w = exp_q.pop_front();
            check({w.tag, " len"}, c_len, w.len);
            check({w.tag, " hs1"}, c_h1, w.h1);
            check({w.tag, " ls1"}, c_l1, w.l1);
            check({w.tag, " hs2"}, c_h2, w.h2);
            check({w.tag, " ls2"}, c_l2, w.l2);
            armed = 0;
          end
          if (exp_q.size() != 0) begin
            armed = 1;
            c_len = 0; c_h1 = 0; c_l1 = 0; c_h2 = 0; c_l2 = 0;
          end
        end
        if (armed) begin
          c_len++; c_h1 += int'(hs1); c_l1 += int'(ls1);
          c_h2 += int'(hs2); c_l2 += int'(ls2);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pos_cycle = 1'b1; duty_cmp = 16'd10; period_in = 16'd40;
    db_len = 8'd3; cbc_trip = 1'b0; dly_trip = 1'b0; stat_force = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 hs1", int'(hs1), 0);
    check("R10 ls1", int'(ls1), 0);
    check("R10 hs2", int'(hs2), 0);
    check("R10 ls2", int'(ls2), 0);
    check("R10 ctr", int'(ctr), 0);
    check("R10 trip_active", int'(trip_active), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1 stat_force = 1'b1;
    @(posedge clk); #1 stat_force = 1'b0;

    // R2 R3 R4 R1: positive half, leg 1 switching
    apply(1, 10, 40, 3, 0, 0);
    expect_win(80, 57, 17, 0, 80, "R2_R3_R4 pos");
    // R5: negative half, roles mirrored
    apply(0, 25, 40, 3, 0, 0);
    expect_win(80, 0, 80, 27, 47, "R5 neg");
    // R2 boundary: compare equal to period
    apply(1, 40, 40, 3, 0, 0);
    expect_win(80, 0, 80, 0, 80, "R2 cmp=P");
    // R2 clamp: compare above period
    apply(1, 60, 40, 3, 0, 0);
    expect_win(80, 0, 80, 0, 80, "R2 clamp");
    // R6: delayed level high clears the parked low side
    apply(1, 10, 40, 3, 0, 1);
    expect_win(80, 57, 17, 0, 0, "R6 dly high");
    apply(1, 10, 40, 3, 0, 0);
    expect_win(80, 57, 17, 0, 80, "R6 dly low");
    // R7: held trip, positive half
    apply(1, 10, 40, 3, 1, 0);
    expect_win(80, 0, 0, 0, 80, "R7 trip pos");
    // R7: held trip, negative half
    apply(0, 10, 40, 3, 1, 0);
    expect_win(80, 0, 80, 0, 0, "R7 trip neg");
    // R3: zero dead time
    apply(0, 20, 40, 0, 0, 0);
    expect_win(80, 0, 80, 40, 40, "R3 db=0");
    // R1: new period
    apply(1, 5, 20, 2, 0, 0);
    expect_win(40, 28, 8, 0, 40, "R1 P=20");

    // R8: one-clock trip pulse mid-window latches until the next zero
    wait_zeros(1);
    repeat (8) @(negedge clk);
    @(posedge clk); #1 cbc_trip = 1'b1;
    @(posedge clk); #1 cbc_trip = 1'b0;
    @(negedge clk);
    check("R8 latched", int'(trip_active), 1);
    check("R7 hs1 blanked", int'(hs1), 0);
    check("R7 ls1 blanked", int'(ls1), 0);
    wait_zeros(1);
    @(negedge clk);
    check("R8 cleared", int'(trip_active), 0);

    // R5: polarity change mid-window waits for the zero point
    wait_zeros(1);
    repeat (5) @(negedge clk);
    @(posedge clk); #1 pos_cycle = 1'b0;
    @(negedge clk);
    check("R5 hold mid-window", int'(cycle_pos), 1);
    wait_zeros(1);
    check("R5 hold at zero", int'(cycle_pos), 1);
    @(negedge clk);
    check("R5 after zero", int'(cycle_pos), 0);

    wait_zeros(2);
    // R9: no overlap on either leg over the whole run
    check("R9 overlap count", n_shoot, 0);
    finish_run();
  end
endmodule